// File: doc/BRIEF.md
# Calibration Sequencer with Tone-Coded Status

This block steps a 32.768 kHz oscillator through a one-time offset calibration at the factory. It has no status register. It shows its progress by changing the frequency of the clock it drives out. A programmable divider, run from a fast modelling clock, makes either the normal clock or one of several status and error tones. A 4-bit select code from the sequencer chooses which one.

After reset the sequencer waits for a reference-present indication and gives the normal clock meanwhile. The timeout for that wait can be set. If the reference arrives in time, a measurement phase runs. A ready phase follows, in which the sequencer waits for the programming-voltage detect. It then issues a one-cycle trim-commit strobe and waits for the memory-write result. A successful write returns the normal frequency. Every failure freezes on its own tone until reset. A reference loss or an out-of-range correction can be retried by cycling power. A burn failure or a lost programming voltage is final.

Half-period units for each tone: normal and trimmed 10, busy 5, ready 16, voltage-seen 32, reference-lost 64, out-of-range 128, burn-failed 256, voltage-lost 512. One unit is `UNIT_CYC` clock cycles.

Top module: `cal_seq_top`

## Requirements
- R1: After reset, tone_sel_o is 0, trim_commit_o is low, and tone_clk_o runs with a period of 20 units.
- R2: If ref_det_i is high while the sequencer waits for the reference, tone_sel_o becomes 1 and the period becomes 10 units.
- R3: If ref_det_i has not been seen by the time the timer reaches ref_lim_i cycles, the sequencer stays in normal mode with tone 0 and no error. A reference that arrives after that is ignored.
- R4: In the measuring state, meas_done_i with meas_oor_i low gives tone 2, with a period of 32 units.
- R5: In the ready state, hv_det_i gives tone 3, with a period of 64 units. trim_commit_o pulses high for exactly one cycle on entry.
- R6: In the burn state, nvm_done_i gives tone 8, with a period of 20 units.
- R7: If ref_det_i is low in the measuring state, tone 4 results, with a period of 128 units. This takes priority over meas_done_i in the same cycle.
- R8: In the measuring state, meas_done_i with meas_oor_i high gives tone 5, with a period of 256 units.
- R9: In the burn state, nvm_fail_i gives tone 6, with a period of 512 units.
- R10: If hv_det_i is low in the burn state, tone 7 results, with a period of 1024 units. This takes priority over nvm_done_i and nvm_fail_i.
- R11: The trimmed state and every error state keep their tone until reset, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast modelling clock |
| rst_ni | input | 1 | Active-low asynchronous reset (power-up) |
| ref_det_i | input | 1 | Reference present on the control pin |
| meas_done_i | input | 1 | Offset measurement finished (pulse) |
| meas_oor_i | input | 1 | Correction is out of the trim range, valid with meas_done_i |
| hv_det_i | input | 1 | Programming voltage detected |
| nvm_done_i | input | 1 | Memory write succeeded (pulse) |
| nvm_fail_i | input | 1 | Memory write failed (pulse) |
| ref_lim_i | input | TMR_W | Reference wait timeout in cycles |
| tone_sel_o | output | 4 | Tone select code |
| tone_clk_o | output | 1 | Divided output clock |
| trim_commit_o | output | 1 | One-cycle strobe that commits the trim value |

## Verification
The bench builds the block with `UNIT_CYC` = 1 and `TMR_W` = 8. With that setting, the slowest error tone has a period of only 1024 cycles. This lets the bench measure the period of every one of the nine tone codes exactly between rising edges of the output clock. It drives every path through the flow: success, each of the four failures, the same-cycle priority conflicts, and reference timeouts at several limits including zero. Each final state is then hit with further input activity, to show that it stays put.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

  typedef enum logic [3:0] {
    TONE_NORM    = 4'd0,
    TONE_BUSY    = 4'd1,
    TONE_READY   = 4'd2,
    TONE_HV      = 4'd3,
    TONE_E_REF   = 4'd4,
    TONE_E_RANGE = 4'd5,
    TONE_E_BURN  = 4'd6,
    TONE_E_HV    = 4'd7,
    TONE_TRIMMED = 4'd8
  } tone_e;

  typedef enum logic [3:0] {
    ST_WAIT_REF,
    ST_FREE,
    ST_MEAS,
    ST_READY,
    ST_BURN,
    ST_DONE,
    ST_E_REF,
    ST_E_RANGE,
    ST_E_BURN,
    ST_E_HV
  } state_e;

  localparam int unsigned MAX_HALF_UNITS = 512;

  function automatic int unsigned tone_half_units(logic [3:0] code);
    case (code)
      TONE_BUSY:    return 5;
      TONE_READY:   return 16;
      TONE_HV:      return 32;
      TONE_E_REF:   return 64;
      TONE_E_RANGE: return 128;
      TONE_E_BURN:  return 256;
      TONE_E_HV:    return 512;
      default:      return 10;
    endcase
  endfunction

endpackage

// File: rtl/cal_ref_timer.sv
module cal_ref_timer #(
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [TMR_W-1:0] lim_i,
  output logic             expired_o
);

  logic [TMR_W-1:0] cnt_q;

  assign expired_o = (cnt_q >= lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (run_i && !expired_o) cnt_q <= cnt_q + 1'b1;
  end

  AST_TMR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && run_i) |=> (expired_o || lim_i != $past(lim_i))); // R3

endmodule

// File: rtl/cal_seq_fsm.sv
module cal_seq_fsm
  import cal_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_det_i,
  input  logic       meas_done_i,
  input  logic       meas_oor_i,
  input  logic       hv_det_i,
  input  logic       nvm_done_i,
  input  logic       nvm_fail_i,
  input  logic       tmr_exp_i,
  output logic       tmr_run_o,
  output logic [3:0] tone_sel_o,
  output logic       commit_o
);

  state_e state_q, state_d;
  logic   commit_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_WAIT_REF: begin
        if (ref_det_i)      state_d = ST_MEAS;
        else if (tmr_exp_i) state_d = ST_FREE;
      end
      ST_MEAS: begin
        // loss of reference outranks a same-cycle result
        if (!ref_det_i)       state_d = ST_E_REF;
        else if (meas_done_i) state_d = meas_oor_i ? ST_E_RANGE : ST_READY;
      end
      ST_READY: if (hv_det_i) state_d = ST_BURN;
      ST_BURN: begin
        if (!hv_det_i)       state_d = ST_E_HV;
        else if (nvm_fail_i) state_d = ST_E_BURN;
        else if (nvm_done_i) state_d = ST_DONE;
      end
      default: state_d = state_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_WAIT_REF;
      commit_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      commit_q <= (state_q == ST_READY) && (state_d == ST_BURN);
    end
  end

  always_comb begin
    case (state_q)
      ST_MEAS:    tone_sel_o = TONE_BUSY;
      ST_READY:   tone_sel_o = TONE_READY;
      ST_BURN:    tone_sel_o = TONE_HV;
      ST_DONE:    tone_sel_o = TONE_TRIMMED;
      ST_E_REF:   tone_sel_o = TONE_E_REF;
      ST_E_RANGE: tone_sel_o = TONE_E_RANGE;
      ST_E_BURN:  tone_sel_o = TONE_E_BURN;
      ST_E_HV:    tone_sel_o = TONE_E_HV;
      default:    tone_sel_o = TONE_NORM;
    endcase
  end

  assign tmr_run_o = (state_q == ST_WAIT_REF);
  assign commit_o  = commit_q;

  AST_FINAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_DONE, ST_E_REF, ST_E_RANGE, ST_E_BURN, ST_E_HV}) |=> $stable(state_q)); // R11
  AST_FREE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FREE) |=> (state_q == ST_FREE)); // R3
  AST_COMMIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |=> !commit_q); // R5
  AST_COMMIT_IN_BURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |-> (state_q == ST_BURN)); // R5
  AST_REF_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_MEAS && !ref_det_i) |=> (state_q == ST_E_REF)); // R7
  AST_HV_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BURN && !hv_det_i) |=> (state_q == ST_E_HV)); // R10

endmodule

// File: rtl/cal_tone_div.sv
module cal_tone_div
  import cal_seq_pkg::*;
#(
  parameter int unsigned UNIT_CYC = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] sel_i,
  output logic       tone_clk_o
);

  localparam int unsigned MAX_HALF = MAX_HALF_UNITS * UNIT_CYC;
  localparam int unsigned CNT_W    = $clog2(MAX_HALF + 1);

  logic [3:0]       sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;
  logic             clk_q;

  assign half_m1 = CNT_W'(tone_half_units(sel_q) * UNIT_CYC - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= TONE_NORM;
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (sel_i != sel_q) begin
      sel_q <= sel_i;
      cnt_q <= '0;
    end else if (cnt_q == half_m1) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tone_clk_o = clk_q;

  AST_DIV_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= half_m1); // R1
  AST_DIV_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i != sel_q) |=> (cnt_q == '0 && $stable(clk_q))); // R2

endmodule

// File: rtl/cal_seq_top.sv
module cal_seq_top
  import cal_seq_pkg::*;
#(
  parameter int unsigned UNIT_CYC = 64,
  parameter int unsigned TMR_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_det_i,
  input  logic             meas_done_i,
  input  logic             meas_oor_i,
  input  logic             hv_det_i,
  input  logic             nvm_done_i,
  input  logic             nvm_fail_i,
  input  logic [TMR_W-1:0] ref_lim_i,
  output logic [3:0]       tone_sel_o,
  output logic             tone_clk_o,
  output logic             trim_commit_o
);

  logic tmr_run, tmr_exp;
  logic [3:0] tone_sel;

  cal_ref_timer #(.TMR_W(TMR_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (tmr_run),
    .lim_i     (ref_lim_i),
    .expired_o (tmr_exp)
  );

  cal_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_det_i   (ref_det_i),
    .meas_done_i (meas_done_i),
    .meas_oor_i  (meas_oor_i),
    .hv_det_i    (hv_det_i),
    .nvm_done_i  (nvm_done_i),
    .nvm_fail_i  (nvm_fail_i),
    .tmr_exp_i   (tmr_exp),
    .tmr_run_o   (tmr_run),
    .tone_sel_o  (tone_sel),
    .commit_o    (trim_commit_o)
  );

  cal_tone_div #(.UNIT_CYC(UNIT_CYC)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (tone_sel),
    .tone_clk_o (tone_clk_o)
  );

  assign tone_sel_o = tone_sel;

  AST_TONE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tone_sel_o <= 4'd8); // R11

endmodule

// File: tb/tb_cal_seq_top.sv
module tb_cal_seq_top;
  localparam time CLK_PER = 10ns;
  localparam int  UNIT    = 1;
  localparam int  TW      = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_det = 0, meas_done = 0, meas_oor = 0, hv_det = 0, nvm_done = 0, nvm_fail = 0;
  logic [TW-1:0] ref_lim = 8'd200;
  logic [3:0] tone;
  logic tone_clk, commit;
  int checks = 0, errors = 0, commit_cnt = 0;

  always #(CLK_PER/2) clk = ~clk;

  cal_seq_top #(.UNIT_CYC(UNIT), .TMR_W(TW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_det_i(ref_det), .meas_done_i(meas_done),
    .meas_oor_i(meas_oor), .hv_det_i(hv_det), .nvm_done_i(nvm_done),
    .nvm_fail_i(nvm_fail), .ref_lim_i(ref_lim), .tone_sel_o(tone),
    .tone_clk_o(tone_clk), .trim_commit_o(commit)
  );

  always @(negedge clk) if (commit) commit_cnt++;

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic period_of(output int cyc);
    time t0, t1;
    @(posedge tone_clk); t0 = $time;
    @(posedge tone_clk); t1 = $time;
    cyc = int'((t1 - t0) / CLK_PER);
  endtask

  task automatic check_tone(string req, int code, int half_units);
    int p;
    check(req, int'(tone), code);
    period_of(p);
    check(req, p, 2 * half_units * UNIT);
    step(1);
  endtask

  task automatic do_reset(logic ref_lvl);
    rst_n = 0; ref_det = ref_lvl; meas_done = 0; meas_oor = 0;
    hv_det = 0; nvm_done = 0; nvm_fail = 0;
    step(3); rst_n = 1; step(1);
    commit_cnt = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1; step(1); s = 0; step(2);
  endtask

  task automatic poke_all(string req, int code);
    ref_det = ~ref_det; meas_done = 1; hv_det = ~hv_det; nvm_done = 1; nvm_fail = 1; meas_oor = 1;
    step(2);
    meas_done = 0; nvm_done = 0; nvm_fail = 0; meas_oor = 0; ref_det = ~ref_det; hv_det = ~hv_det;
    step(3);
    check(req, int'(tone), code);
  endtask

  task automatic to_ready;
    ref_det = 1; step(2); pulse(meas_done);
  endtask

  task automatic to_burn;
    to_ready(); ref_det = 0; hv_det = 1; step(3);
  endtask

  initial begin
    #(CLK_PER * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // success path
    do_reset(0);
    check("R1 commit", int'(commit), 0);
    check_tone("R1", 0, 10);
    ref_det = 1; step(2);
    check_tone("R2", 1, 5);
    pulse(meas_done);
    check_tone("R4", 2, 16);
    ref_det = 0; hv_det = 1; step(3);
    check("R5 commit count", commit_cnt, 1);
    check_tone("R5", 3, 32);
    check("R5 single strobe", commit_cnt, 1);
    pulse(nvm_done);
    check_tone("R6", 8, 10);
    poke_all("R11 trimmed", 8);
    check("R11 no new commit", commit_cnt, 1);

    // reference lost, same cycle as done
    do_reset(0);
    ref_det = 1; step(2);
    ref_det = 0; meas_done = 1; step(1); meas_done = 0; step(2);
    check_tone("R7", 4, 64);
    poke_all("R11 ref lost", 4);

    // out of range
    do_reset(0);
    ref_det = 1; step(2);
    meas_oor = 1; meas_done = 1; step(1); meas_done = 0; meas_oor = 0; step(2);
    check_tone("R8", 5, 128);
    poke_all("R11 range", 5);

    // burn failure
    do_reset(0);
    to_burn();
    pulse(nvm_fail);
    check_tone("R9", 6, 256);
    poke_all("R11 burn", 6);

    // voltage lost with done in same cycle
    do_reset(0);
    to_burn();
    hv_det = 0; nvm_done = 1; step(1); nvm_done = 0; step(2);
    check_tone("R10", 7, 512);
    poke_all("R11 hv lost", 7);

    // ready state waits for voltage indefinitely
    do_reset(0);
    to_ready(); ref_det = 0; step(50);
    check("R5 ready holds", int'(tone), 2);
    check("R5 no early commit", commit_cnt, 0);

    // reference timeout sweep
    for (int i = 0; i < 4; i++) begin
      int lim;
      lim = (i == 0) ? 0 : i * 9;
      ref_lim = TW'(lim);
      do_reset(0);
      step(lim + 6);
      ref_det = 1; step(3);
      check("R3 late ref ignored", int'(tone), 0);
      step(10);
      check("R3 stays normal", int'(tone), 0);
      if (lim > 8) begin
        do_reset(0);
        step(lim / 2);
        ref_det = 1; step(2);
        check("R3 ref within limit", int'(tone), 1);
      end
    end
    ref_lim = 8'd0;
    do_reset(1);
    step(2);
    check("R3 ref beats zero limit", int'(tone), 1);
    check_tone("R3", 1, 5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule